// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit up-counter that serves three jobs, picked by software: a free-running interval timer that reloads itself when it passes its top value, an event timestamper that copies the running count when a trigger pin rises, and a frequency meter that counts edges on an external pin over a fixed gate window. In interval mode every wrap flips a dedicated overflow pin, so the pin gives a square wave whose period is set by the reload value.

The count step comes from one of four sources: a slow clock-enable pulse, a fast clock-enable pulse, rising edges of an asynchronous external pin, or nothing. The external clock pin and the trigger pin are both resynchronised into the system clock domain before any edge is used. Software reaches the block through a 4-bit write/read port with a 4-bit address. Wraps, captures and gate closures all set one sticky interrupt flag, and software clears that flag through the same port.

Top module: `tmr16_unit`

## Requirements
- R1: After reset the counter, reload value, capture value, control fields, run bit, interrupt flag and overflow pin are all zero.
- R2: Address 0 holds the mode in bits [1:0] and the source in bits [3:2]. At address 1, bit 0 is the run bit and bit 1 reads as the interrupt flag. Writing run from 0 to 1 is a start: it loads the counter with the reload value, or with zero in frequency mode. Addresses 2 and 3 read as zero.
- R3: Mode 0 (interval): each selected tick adds one to the counter. The tick that finds the counter at 0xFFFF loads the reload value instead, flips the overflow pin and sets the interrupt flag.
- R4: Mode 1 (capture): the counter counts and reloads as in R3. A rising edge on the trigger pin copies the current count into the capture register and sets the interrupt flag, and counting goes on without a break.
- R5: Mode 2 (frequency): the counter counts synchronised external rising edges whatever the source field holds. Each slow tick closes a window: it copies the count into the capture register, restarts the counter (an edge in that same cycle counts as 1 in the new window) and sets the interrupt flag.
- R6: Source codes are 0 for the slow tick, 1 for the fast tick, 2 for synchronised external rising edges and 3 for no tick.
- R7: The external clock pin and the trigger pin each pass through a two-stage synchroniser and a rising-edge detector. A level change made before clock edge k takes effect at edge k+2, and each rising edge gives exactly one event.
- R8: Writing address 1 with bit 1 set clears the interrupt flag. If an event occurs in the same cycle, the flag stays set.
- R9: While run is 0, or while mode is 3, the counter holds its value.
- R10: Addresses 4-7, 8-11 and 12-15 read nibbles 0-3, least significant first, of the reload value, the live count and the capture value. Writes to 4-7 set the matching reload nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow clock-enable pulse; also ends each frequency gate window |
| fast_tick | input | 1 | Fast clock-enable pulse |
| ext_pin | input | 1 | Asynchronous external count clock |
| cap_pin | input | 1 | Asynchronous capture trigger |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data (combinational) |
| ovf_pin | output | 1 | Overflow pin, flips on every wrap |
| irq | output | 1 | Sticky timer interrupt request |

## Verification
On every cycle the assertions check that the counter steps by one or takes the reload value exactly after a wrap, that the overflow pin moves only on a wrap, that a capture or gate closure copies the prior count, that a held or stopped counter does not move, that the edge detector pulses for one cycle at most, and that the interrupt flag obeys its set and clear rules. Only the bench scenarios can show the end-to-end figures. These are the wrap rate swept over sixteen reload values, the exact two-edge synchroniser latency shown through captured timestamps, the edge counts per gate window for several input frequencies, and the count gained from the slow source.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_RELOAD  = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_FREQ    = 2'd2,
    MODE_HOLD    = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_FAST = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_NONE = 2'd3
  } tmr_src_e;

  localparam logic [3:0] ADR_CTRL   = 4'd0;
  localparam logic [3:0] ADR_RUN    = 4'd1;
  localparam logic [3:0] ADR_RELOAD = 4'd4;

  localparam logic [1:0] GRP_CTRL   = 2'd0;
  localparam logic [1:0] GRP_RELOAD = 2'd1;
  localparam logic [1:0] GRP_COUNT  = 2'd2;
  localparam logic [1:0] GRP_CAPT   = 2'd3;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              level;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin};
    end
  endgenerate

  assign level = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;

  assign rise = level & ~prev_q;

  // R7: one rising edge yields a single-cycle event
  p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       addr,
  input  logic [3:0]       wdata,
  output logic [3:0]       rdata,
  input  logic             ev_any,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] capt,
  output tmr_mode_e        mode,
  output tmr_src_e         src,
  output logic             run,
  output logic             start,
  output logic [WIDTH-1:0] reload,
  output logic             irq
);
  localparam int NIB = WIDTH / 4;

  logic wr_ctrl, wr_run, irq_clr;

  function automatic logic [3:0] nib_of(input logic [WIDTH-1:0] v, input logic [1:0] idx);
    logic [WIDTH-1:0] sh;
    sh = v >> {idx, 2'b00};
    return sh[3:0];
  endfunction

  assign wr_ctrl = we && (addr == ADR_CTRL);
  assign wr_run  = we && (addr == ADR_RUN);
  assign start   = wr_run && wdata[0] && !run;
  assign irq_clr = wr_run && wdata[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= MODE_RELOAD;
      src  <= SRC_SLOW;
    end else if (wr_ctrl) begin
      mode <= tmr_mode_e'(wdata[1:0]);
      src  <= tmr_src_e'(wdata[3:2]);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      run <= 1'b0;
    else if (wr_run) run <= wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       irq <= 1'b0;
    else if (ev_any)  irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;

  generate
    for (genvar i = 0; i < NIB; i++) begin : g_reload
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          reload[4*i +: 4] <= 4'h0;
        else if (we && (addr == (ADR_RELOAD | 4'(i))))
          reload[4*i +: 4] <= wdata;
    end
  endgenerate

  always_comb begin
    rdata = 4'h0;
    unique case (addr[3:2])
      GRP_CTRL:   if (!addr[1]) rdata = addr[0] ? {2'b00, irq, run} : {src, mode};
      GRP_RELOAD: rdata = nib_of(reload, addr[1:0]);
      GRP_COUNT:  rdata = nib_of(cnt, addr[1:0]);
      GRP_CAPT:   rdata = nib_of(capt, addr[1:0]);
    endcase
  end

  // R8: any event leaves the flag set
  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |=> irq);
  // R8: a clear with no competing event drops the flag
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !ev_any) |=> !irq);
  // R2: a start leaves the block running
  p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode,
  input  tmr_src_e         src,
  input  logic             run,
  input  logic             start,
  input  logic [WIDTH-1:0] reload,
  input  logic             slow_tick,
  input  logic             fast_tick,
  input  logic             ext_rise,
  input  logic             cap_rise,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] capt,
  output logic             ovf_q,
  output logic             ev_any
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;
  localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

  logic tick, active, counts_ticks;
  logic ovf_evt, cap_evt, gate_evt;

  function automatic logic [WIDTH-1:0] tick_next(input logic [WIDTH-1:0] c,
                                                 input logic [WIDTH-1:0] r);
    return (c == CNT_MAX) ? r : c + CNT_ONE;
  endfunction

  function automatic logic [WIDTH-1:0] sat_inc(input logic [WIDTH-1:0] c);
    return (c == CNT_MAX) ? c : c + CNT_ONE;
  endfunction

  always_comb begin
    unique case (src)
      SRC_SLOW: tick = slow_tick;
      SRC_FAST: tick = fast_tick;
      SRC_EXT:  tick = ext_rise;
      SRC_NONE: tick = 1'b0;
    endcase
  end

  assign active       = run && !start;
  assign counts_ticks = (mode == MODE_RELOAD) || (mode == MODE_CAPTURE);
  assign ovf_evt      = active && counts_ticks && tick && (cnt == CNT_MAX);
  assign cap_evt      = active && (mode == MODE_CAPTURE) && cap_rise;
  assign gate_evt     = active && (mode == MODE_FREQ) && slow_tick;
  assign ev_any       = ovf_evt || cap_evt || gate_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= (mode == MODE_FREQ) ? '0 : reload;
    end else if (run) begin
      unique case (mode)
        MODE_RELOAD, MODE_CAPTURE: if (tick) cnt <= tick_next(cnt, reload);
        MODE_FREQ: begin
          if (slow_tick)     cnt <= ext_rise ? CNT_ONE : '0;
          else if (ext_rise) cnt <= sat_inc(cnt);
        end
        MODE_HOLD: cnt <= cnt;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   capt <= '0;
    else if (cap_evt || gate_evt) capt <= cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ovf_q <= 1'b0;
    else if (ovf_evt) ovf_q <= ~ovf_q;

  // R3: a wrap loads the reload value
  p_wrap_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == $past(reload)));
  // R3: ordinary ticks add one
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && counts_ticks && tick && (cnt != CNT_MAX)) |=> (cnt == $past(cnt) + CNT_ONE));
  // R3: the overflow pin moves only on a wrap
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_evt |=> $stable(ovf_q));
  // R4: a capture stores the pre-edge count
  p_capture_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (capt == $past(cnt)));
  // R5: a closed window restarts the counter at 0 or 1
  p_gate_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_evt |=> (cnt <= CNT_ONE));
  // R9: stopped or held counter keeps its value
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!run || mode == MODE_HOLD) && !start) |=> $stable(cnt));

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       fast_tick,
  input  logic       ext_pin,
  input  logic       cap_pin,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [3:0] reg_wdata,
  output logic [3:0] reg_rdata,
  output logic       ovf_pin,
  output logic       irq
);
  logic             ext_rise, cap_rise;
  logic             run, start, ev_any;
  tmr_mode_e        mode;
  tmr_src_e         src;
  logic [WIDTH-1:0] reload, cnt, capt;

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(ext_rise));

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(cap_rise));

  tmr_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ev_any(ev_any), .cnt(cnt), .capt(capt), .mode(mode),
    .src(src), .run(run), .start(start), .reload(reload), .irq(irq));

  tmr_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .src(src), .run(run), .start(start),
    .reload(reload), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .ext_rise(ext_rise), .cap_rise(cap_rise), .cnt(cnt), .capt(capt),
    .ovf_q(ovf_pin), .ev_any(ev_any));

endmodule

// File: tb/sim_tmr16_unit.sv
`timescale 1ns/100ps
module sim_tmr16_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0, fast_tick = 1'b0, ext_pin = 1'b0, cap_pin = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'h0, reg_wdata = 4'h0;
  logic [3:0] reg_rdata;
  logic       ovf_pin, irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ext_period = 0;
  logic ext_manual = 1'b0;
  logic slow_en = 1'b0;

  tmr16_unit u0 (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .ext_pin(ext_pin), .cap_pin(cap_pin), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_pin(ovf_pin), .irq(irq));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk);
    slow_tick = slow_en && (cyc % 32 == 0);
    ext_pin   = (ext_period != 0) ? ((cyc % ext_period) < ext_period / 2) : ext_manual;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 4'h0;
  endtask

  task automatic rd16(input logic [3:0] base, output logic [15:0] v);
    for (int i = 0; i < 4; i++) begin
      reg_addr = base + 4'(i);
      #1 v[4*i +: 4] = reg_rdata;
    end
    reg_addr = 4'h0;
  endtask

  task automatic rd4(input logic [3:0] a, output logic [3:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
    reg_addr = 4'h0;
  endtask

  task automatic set_reload(input logic [15:0] r);
    for (int i = 0; i < 4; i++) wr(4'd4 + 4'(i), r[4*i +: 4]);
  endtask

  // stop, clear flag, start: returns at the low phase after the start edge
  task automatic restart();
    wr(4'd1, 4'b0010);
    wr(4'd1, 4'b0001);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v16, c1;
    logic [3:0]  v4;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ovf_pin", ovf_pin, 0);
    check("R1 irq", irq, 0);
    rd16(4'd4, v16);  check("R1 reload", v16, 0);
    rd16(4'd8, v16);  check("R1 count", v16, 0);
    rd16(4'd12, v16); check("R1 capture", v16, 0);
    rd4(4'd0, v4);    check("R1 ctrl", v4, 0);
    rd4(4'd1, v4);    check("R1 run/flag", v4, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R10 register readback
    wr(4'd0, 4'b0100);
    rd4(4'd0, v4); check("R2 ctrl readback", v4, 4'b0100);
    rd4(4'd2, v4); check("R2 addr2 zero", v4, 0);
    set_reload(16'hA5C3);
    rd16(4'd4, v16); check("R10 reload readback", v16, 16'hA5C3);

    // R3 sweep of reload values near the top, fast source every cycle
    fast_tick = 1'b1;
    for (int r = 16'hFFF0; r <= 16'hFFFF; r++) begin
      int p, tog;
      logic prev;
      p = 65536 - r;
      wr(4'd1, 4'b0010);
      set_reload(16'(r));
      restart();
      prev = ovf_pin; tog = 0;
      for (int n = 0; n < 100; n++) begin
        @(negedge clk);
        if (ovf_pin != prev) tog++;
        prev = ovf_pin;
      end
      check($sformatf("R3 wraps reload=%0h", r), tog, 100 / p);
      rd16(4'd8, v16);
      check($sformatf("R3 count reload=%0h", r), v16, r + (100 % p));
      check("R3 irq after wrap", irq, 1);
    end

    // R4 / R7 capture timestamps: trigger raised after start edge + a edges
    wr(4'd0, 4'b0101);
    for (int a = 0; a < 8; a++) begin
      wr(4'd1, 4'b0010);
      cap_pin = 1'b0;
      set_reload(16'h1000);
      repeat (4) @(negedge clk);
      restart();
      check("R8 flag cleared before capture", irq, 0);
      repeat (a) @(negedge clk);
      cap_pin = 1'b1;
      repeat (5) @(negedge clk);
      rd16(4'd12, v16);
      check($sformatf("R7 R4 capture value a=%0d", a), v16, 16'h1000 + a + 2);
      rd16(4'd8, v16);
      check($sformatf("R4 counting continues a=%0d", a), v16, 16'h1000 + a + 5);
      check("R4 irq on capture", irq, 1);
    end
    // R8 clear while running, no restart
    wr(4'd1, 4'b0011);
    check("R8 irq cleared", irq, 0);
    rd4(4'd1, v4); check("R8 R2 run kept, flag read", v4, 4'b0001);
    cap_pin = 1'b0;

    // R5 frequency measurement, window = 32 cycles
    fast_tick = 1'b0;
    wr(4'd0, 4'b1110);
    slow_en = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      int p;
      p = 1 << k;
      ext_period = p;
      restart();
      repeat (110) @(negedge clk);
      rd16(4'd12, v16);
      check($sformatf("R5 edges per window period=%0d", p), v16, 32 / p);
      check("R5 irq on gate", irq, 1);
    end
    ext_period = 0;

    // R6 slow source, fast tick also active but ignored
    fast_tick = 1'b1;
    wr(4'd0, 4'b0000);
    set_reload(16'h0100);
    restart();
    begin
      int nt;
      nt = 0;
      for (int n = 0; n < 100; n++) begin
        if (cyc % 32 == 0) nt++;
        @(negedge clk);
      end
      rd16(4'd8, v16);
      check("R6 slow source count", v16, 16'h0100 + nt);
    end
    slow_en = 1'b0;

    // R6 no source
    wr(4'd0, 4'b1100);
    restart();
    repeat (20) @(negedge clk);
    rd16(4'd8, v16); check("R6 none source holds", v16, 16'h0100);

    // R6 / R7 external source, three manual pulses
    wr(4'd0, 4'b1000);
    restart();
    for (int n = 0; n < 3; n++) begin
      ext_manual = 1'b1; repeat (3) @(negedge clk);
      ext_manual = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd16(4'd8, v16); check("R6 R7 external edges counted", v16, 16'h0103);

    // R9 hold mode with fast source
    wr(4'd0, 4'b0111);
    restart();
    repeat (10) @(negedge clk);
    rd16(4'd8, v16); check("R9 hold mode keeps reload", v16, 16'h0100);

    // R9 stop freezes a running counter
    wr(4'd0, 4'b0100);
    restart();
    repeat (10) @(negedge clk);
    wr(4'd1, 4'b0000);
    rd16(4'd8, c1);
    repeat (10) @(negedge clk);
    rd16(4'd8, v16); check("R9 stopped counter frozen", v16, c1);
    check("R9 counter advanced before stop", (c1 > 16'h0100) ? 1 : 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule